// File: doc/BRIEF.md
# Shadow Register Context Switch Controller

This block changes the running task of a processor without executing any instructions. It keeps two register sets. The CPU sees only the active set. The hidden standby set is filled with the next task's saved registers from a dual-ported task-state memory. Once that fill is complete, the two sets trade roles in a single cycle. The outgoing task's registers are then copied back to its memory block through the memory's second port. Each task owns one block in that memory. The memory address is the task number in the upper bits and the register index in the lower bits.

An external arbiter supplies the current bid winner (task number and bid). A bid of zero means no task is bidding. The CPU pipeline raises a stall input when the running task is waiting on memory, an input read, a cache miss or a busy resource. From the running task, the preloaded standby task and the winner, the controller decides each cycle to keep running, to preload and swap, or to drop to idle. The memory returns read data one cycle after a read is issued.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: While reset is applied, and after its release until a bid arrives, `idle` is 1, `run_valid` is 0, and neither memory port is enabled.
- R2: When a task runs, `cpu_rdata` returns that task's register at `cpu_raddr`, and a `cpu_we` write updates that task's register at `cpu_waddr` from the next cycle on. When idle, `cpu_rdata` is 0.
- R3: A preload reads the winner's block in ascending register order, one read per cycle, at address {task, index}. If the controller is idle and a nonzero bid arrives, the winner is running NUM_REGS+3 clock edges after the bid is first presented.
- R4: A running task is replaced only by the current winner. A different winner replaces it only if the running task is stalled or the winner's bid is strictly greater than the running task's bid. A ready standby swaps in during the first cycle this holds.
- R5: A stalled running task that is itself the winner keeps running.
- R6: When the winner's bid is zero and no transfer is in progress, the running task leaves on the next edge, and `idle` rises. A task leaves to idle only in that case.
- R7: From the cycle after a task leaves, its NUM_REGS registers are written to its block, one per cycle, in ascending index order, with the values they held when it left.
- R8: The two memory ports are never active in the same cycle. A preload does not start while a write-back is in progress.
- R9: A task that is switched out and later resumed sees exactly the register values it left with, over any sequence of bids, stalls and CPU writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| win_id | input | TID_W | Task number of the arbitration winner |
| win_bid | input | BID_W | Winner's bid; zero means no task bids |
| stall | input | 1 | Running task is blocked on a resource |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_waddr | input | RIDX_W | CPU write register index |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_raddr | input | RIDX_W | CPU read register index |
| cpu_rdata | output | DATA_W | Active-set read data |
| mem_rd_en | output | 1 | Task memory read enable (preload port) |
| mem_rd_addr | output | TID_W+RIDX_W | Task memory read address {task, index} |
| mem_rd_data | input | DATA_W | Task memory read data, one cycle after the read |
| mem_wr_en | output | 1 | Task memory write enable (write-back port) |
| mem_wr_addr | output | TID_W+RIDX_W | Task memory write address {task, index} |
| mem_wr_data | output | DATA_W | Task memory write data |
| run_valid | output | 1 | A task occupies the active set |
| run_id | output | TID_W | Number of the running task |
| idle | output | 1 | No task is running |

## Verification
The hardest case to reach is a swap whose standby set was preloaded earlier and then left waiting. The winner must move to a task with a lower bid than the running one, stay there for the whole fill, and only later have its bid raised past the running task's. This makes the swap happen in the same cycle as the bid change, while the write-back of the outgoing task starts behind it. A directed sequence produces exactly this case and then follows each write-back beat. A long random phase follows, with a fixed seed. It holds winners for random spans, mixes stalls, zero bids and CPU writes, and catches swaps that land in the same cycle as a CPU write. A bench-side copy of every task's registers checks each read and finally the whole memory.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  // Decision taken by the scheduler in one cycle
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_SWAP   = 2'd1,
    ACT_RETIRE = 2'd2
  } ctx_act_e;

endpackage

// File: rtl/ctx_regbank.sv
module ctx_regbank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int RIDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_sel,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic [RIDX_W-1:0] cpu_waddr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [RIDX_W-1:0] cpu_raddr,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              ld_we,
  input  logic [RIDX_W-1:0] ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [RIDX_W-1:0] wb_idx,
  output logic [DATA_W-1:0] wb_data
);

  logic [DATA_W-1:0] bank_w [2][NUM_REGS];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic              cpu_hit;
      logic              ld_hit;
      logic              reg_en;
      logic [DATA_W-1:0] reg_d;
      logic [DATA_W-1:0] reg_q;

      // CPU writes reach only the active bank, preload only the standby bank
      always_comb begin
        cpu_hit = cpu_en && cpu_we && (act_sel == 1'(b)) && (cpu_waddr == RIDX_W'(i));
        ld_hit  = ld_we && (act_sel != 1'(b)) && (ld_idx == RIDX_W'(i));
        reg_en  = cpu_hit || ld_hit;
        reg_d   = cpu_hit ? cpu_wdata : ld_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          reg_q <= '0;
        end else if (reg_en) begin
          reg_q <= reg_d;
        end
      end

      assign bank_w[b][i] = reg_q;
    end
  end

  always_comb begin
    cpu_rdata = cpu_en ? bank_w[act_sel][cpu_raddr] : '0;
    wb_data   = bank_w[~act_sel][wb_idx];
  end

endmodule

// File: rtl/ctx_xfer.sv
module ctx_xfer #(
  parameter int NUM_TASKS = 8,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  localparam int TID_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int RIDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int MADDR_W  = TID_W + RIDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_start,
  input  logic [TID_W-1:0]   ld_tid,
  input  logic               wb_start,
  input  logic [TID_W-1:0]   wb_tid,
  output logic               mem_rd_en,
  output logic [MADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0]  mem_rd_data,
  output logic               bank_we,
  output logic [RIDX_W-1:0]  bank_idx,
  output logic [DATA_W-1:0]  bank_data,
  output logic               ld_busy,
  output logic               ld_done,
  output logic               mem_wr_en,
  output logic [MADDR_W-1:0] mem_wr_addr,
  output logic [RIDX_W-1:0]  wb_idx,
  output logic               wb_busy
);

  localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(NUM_REGS - 1);

  logic              rd_act_q, rd_act_d;
  logic [RIDX_W-1:0] rd_cnt_q, rd_cnt_d;
  logic [TID_W-1:0]  rd_tid_q;
  logic              rd_tid_en;
  logic              cap_v_q;
  logic [RIDX_W-1:0] cap_idx_q;
  logic              wr_act_q, wr_act_d;
  logic [RIDX_W-1:0] wr_cnt_q, wr_cnt_d;
  logic [TID_W-1:0]  wr_tid_q;
  logic              wr_tid_en;

  // Read issue walks 0..LAST; data lands one cycle later in the capture stage
  always_comb begin
    rd_tid_en = ld_start && !rd_act_q;
    if (rd_act_q) begin
      rd_act_d = (rd_cnt_q != LAST_IDX);
      rd_cnt_d = rd_cnt_q + 1'b1;
    end else begin
      rd_act_d = ld_start;
      rd_cnt_d = '0;
    end
  end

  always_comb begin
    wr_tid_en = wb_start && !wr_act_q;
    if (wr_act_q) begin
      wr_act_d = (wr_cnt_q != LAST_IDX);
      wr_cnt_d = wr_cnt_q + 1'b1;
    end else begin
      wr_act_d = wb_start;
      wr_cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q  <= 1'b0;
      rd_cnt_q  <= '0;
      cap_v_q   <= 1'b0;
      cap_idx_q <= '0;
      wr_act_q  <= 1'b0;
      wr_cnt_q  <= '0;
    end else begin
      rd_act_q  <= rd_act_d;
      rd_cnt_q  <= rd_cnt_d;
      cap_v_q   <= rd_act_q;
      cap_idx_q <= rd_cnt_q;
      wr_act_q  <= wr_act_d;
      wr_cnt_q  <= wr_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_tid_q <= '0;
    end else if (rd_tid_en) begin
      rd_tid_q <= ld_tid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_tid_q <= '0;
    end else if (wr_tid_en) begin
      wr_tid_q <= wb_tid;
    end
  end

  always_comb begin
    mem_rd_en   = rd_act_q;
    mem_rd_addr = {rd_tid_q, rd_cnt_q};
    bank_we     = cap_v_q;
    bank_idx    = cap_idx_q;
    bank_data   = mem_rd_data;
    ld_busy     = rd_act_q || cap_v_q;
    ld_done     = cap_v_q && (cap_idx_q == LAST_IDX);
    mem_wr_en   = wr_act_q;
    mem_wr_addr = {wr_tid_q, wr_cnt_q};
    wb_idx      = wr_cnt_q;
    wb_busy     = wr_act_q;
  end

endmodule

// File: rtl/ctx_sched.sv
module ctx_sched #(
  parameter int NUM_TASKS = 8,
  parameter int BID_W     = 4,
  localparam int TID_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] win_id,
  input  logic [BID_W-1:0] win_bid,
  input  logic             stall,
  input  logic             ld_busy,
  input  logic             ld_done,
  input  logic             wb_busy,
  output logic             act_sel,
  output logic             run_valid,
  output logic [TID_W-1:0] run_id,
  output logic             ld_start,
  output logic [TID_W-1:0] ld_tid,
  output logic             wb_start,
  output logic [TID_W-1:0] wb_tid
);

  import ctx_pkg::*;

  logic             sel_q, sel_d;
  logic             run_v_q, run_v_d;
  logic [TID_W-1:0] run_id_q, run_id_d;
  logic [BID_W-1:0] run_bid_q, run_bid_d;
  logic             sb_v_q, sb_v_d;
  logic [TID_W-1:0] sb_id_q, sb_id_d;
  logic [TID_W-1:0] pend_id_q;
  logic             pend_en;

  logic     bid_any;
  logic     foreign;
  logic     may_take;
  ctx_act_e act;

  always_comb begin
    bid_any  = |win_bid;
    foreign  = bid_any && (!run_v_q || (win_id != run_id_q));
    may_take = !run_v_q || stall || (win_bid > run_bid_q);

    if (sb_v_q && foreign && (win_id == sb_id_q) && may_take) begin
      act = ACT_SWAP;
    end else if (run_v_q && !bid_any && !ld_busy && !wb_busy) begin
      act = ACT_RETIRE;
    end else begin
      act = ACT_HOLD;
    end

    // Speculative fill: start as soon as a foreign winner shows up
    ld_start = foreign && !sb_v_q && !ld_busy && !wb_busy;
    pend_en  = ld_start;
    ld_tid   = win_id;
    wb_start = (act == ACT_RETIRE) || ((act == ACT_SWAP) && run_v_q);
    wb_tid   = run_id_q;
  end

  always_comb begin
    sel_d     = sel_q;
    run_v_d   = run_v_q;
    run_id_d  = run_id_q;
    run_bid_d = run_bid_q;
    sb_v_d    = sb_v_q;
    sb_id_d   = sb_id_q;

    unique case (act)
      ACT_SWAP: begin
        sel_d     = ~sel_q;
        run_v_d   = 1'b1;
        run_id_d  = sb_id_q;
        run_bid_d = win_bid;
        sb_v_d    = 1'b0;
      end
      ACT_RETIRE: begin
        sel_d   = ~sel_q;
        run_v_d = 1'b0;
        sb_v_d  = 1'b0;
      end
      default: begin
        if (run_v_q && bid_any && (win_id == run_id_q)) begin
          run_bid_d = win_bid;
        end
        if (ld_done) begin
          sb_v_d  = 1'b1;
          sb_id_d = pend_id_q;
        end else if (sb_v_q && (!bid_any || (win_id != sb_id_q))) begin
          sb_v_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      run_v_q   <= 1'b0;
      run_id_q  <= '0;
      run_bid_q <= '0;
      sb_v_q    <= 1'b0;
      sb_id_q   <= '0;
    end else begin
      sel_q     <= sel_d;
      run_v_q   <= run_v_d;
      run_id_q  <= run_id_d;
      run_bid_q <= run_bid_d;
      sb_v_q    <= sb_v_d;
      sb_id_q   <= sb_id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_id_q <= '0;
    end else if (pend_en) begin
      pend_id_q <= win_id;
    end
  end

  assign act_sel   = sel_q;
  assign run_valid = run_v_q;
  assign run_id    = run_id_q;

endmodule

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl #(
  parameter int NUM_TASKS = 8,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  parameter int BID_W     = 4,
  localparam int TID_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int RIDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int MADDR_W  = TID_W + RIDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TID_W-1:0]   win_id,
  input  logic [BID_W-1:0]   win_bid,
  input  logic               stall,
  input  logic               cpu_we,
  input  logic [RIDX_W-1:0]  cpu_waddr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic [RIDX_W-1:0]  cpu_raddr,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               mem_rd_en,
  output logic [MADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0]  mem_rd_data,
  output logic               mem_wr_en,
  output logic [MADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0]  mem_wr_data,
  output logic               run_valid,
  output logic [TID_W-1:0]   run_id,
  output logic               idle
);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              act_sel;
  logic              ld_start, ld_busy, ld_done;
  logic [TID_W-1:0]  ld_tid;
  logic              wb_start, wb_busy;
  logic [TID_W-1:0]  wb_tid;
  logic              bank_we;
  logic [RIDX_W-1:0] bank_idx;
  logic [DATA_W-1:0] bank_data;
  logic [RIDX_W-1:0] wb_idx;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  ctx_sched #(
    .NUM_TASKS (NUM_TASKS),
    .BID_W     (BID_W)
  ) u_sched (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .win_id    (win_id),
    .win_bid   (win_bid),
    .stall     (stall),
    .ld_busy   (ld_busy),
    .ld_done   (ld_done),
    .wb_busy   (wb_busy),
    .act_sel   (act_sel),
    .run_valid (run_valid),
    .run_id    (run_id),
    .ld_start  (ld_start),
    .ld_tid    (ld_tid),
    .wb_start  (wb_start),
    .wb_tid    (wb_tid)
  );

  ctx_xfer #(
    .NUM_TASKS (NUM_TASKS),
    .NUM_REGS  (NUM_REGS),
    .DATA_W    (DATA_W)
  ) u_xfer (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .ld_start    (ld_start),
    .ld_tid      (ld_tid),
    .wb_start    (wb_start),
    .wb_tid      (wb_tid),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .bank_we     (bank_we),
    .bank_idx    (bank_idx),
    .bank_data   (bank_data),
    .ld_busy     (ld_busy),
    .ld_done     (ld_done),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .wb_idx      (wb_idx),
    .wb_busy     (wb_busy)
  );

  ctx_regbank #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .act_sel   (act_sel),
    .cpu_en    (run_valid),
    .cpu_we    (cpu_we),
    .cpu_waddr (cpu_waddr),
    .cpu_wdata (cpu_wdata),
    .cpu_raddr (cpu_raddr),
    .cpu_rdata (cpu_rdata),
    .ld_we     (bank_we),
    .ld_idx    (bank_idx),
    .ld_data   (bank_data),
    .wb_idx    (wb_idx),
    .wb_data   (mem_wr_data)
  );

  assign idle = !run_valid;

endmodule

// File: rtl/ctx_switch_chk.sv
module ctx_switch_chk #(
  parameter int NUM_TASKS = 8,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  parameter int BID_W     = 4,
  localparam int TID_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int RIDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int MADDR_W  = TID_W + RIDX_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [TID_W-1:0]   win_id,
  input logic [BID_W-1:0]   win_bid,
  input logic               stall,
  input logic               cpu_we,
  input logic [RIDX_W-1:0]  cpu_waddr,
  input logic [DATA_W-1:0]  cpu_wdata,
  input logic [RIDX_W-1:0]  cpu_raddr,
  input logic [DATA_W-1:0]  cpu_rdata,
  input logic               mem_rd_en,
  input logic [MADDR_W-1:0] mem_rd_addr,
  input logic [DATA_W-1:0]  mem_rd_data,
  input logic               mem_wr_en,
  input logic [MADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0]  mem_wr_data,
  input logic               run_valid,
  input logic [TID_W-1:0]   run_id,
  input logic               idle
);

  localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(NUM_REGS - 1);

  AST_PORTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R8

  AST_RD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && (mem_rd_addr[RIDX_W-1:0] != LAST_IDX))
      |=> (mem_rd_en && (mem_rd_addr == $past(mem_rd_addr) + 1'b1))); // R3

  AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && (mem_wr_addr[RIDX_W-1:0] != LAST_IDX))
      |=> (mem_wr_en && (mem_wr_addr == $past(mem_wr_addr) + 1'b1))); // R7

  AST_WB_FOLLOWS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_valid) && (!run_valid || (run_id != $past(run_id))))
      |-> (mem_wr_en && (mem_wr_addr == {$past(run_id), RIDX_W'(0)}))); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && stall && (win_id == run_id) && (win_bid != '0))
      |=> (run_valid && (run_id == $past(run_id)))); // R5

  AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_valid) && !run_valid) |-> ($past(win_bid) == '0)); // R6

  AST_SWAP_TO_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && (!$past(run_valid) || (run_id != $past(run_id))))
      |-> (run_id == $past(win_id))); // R4

endmodule

bind ctx_switch_ctrl ctx_switch_chk #(
  .NUM_TASKS (NUM_TASKS),
  .NUM_REGS  (NUM_REGS),
  .DATA_W    (DATA_W),
  .BID_W     (BID_W)
) u_chk (.*);

// File: tb/tb_ctx_switch_ctrl.sv
`timescale 1ns/1ps
module tb_ctx_switch_ctrl;

  localparam int NT = 8;
  localparam int NR = 8;
  localparam int DW = 32;
  localparam int BW = 4;
  localparam int TW = 3;
  localparam int RW = 3;
  localparam int AW = TW + RW;

  logic          clk;
  logic          rst_n;
  logic [TW-1:0] win_id;
  logic [BW-1:0] win_bid;
  logic          stall;
  logic          cpu_we;
  logic [RW-1:0] cpu_waddr;
  logic [DW-1:0] cpu_wdata;
  logic [RW-1:0] cpu_raddr;
  logic [DW-1:0] cpu_rdata;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          run_valid;
  logic [TW-1:0] run_id;
  logic          idle;

  logic [DW-1:0] tmem [NT*NR];
  logic [DW-1:0] exp_r [NT][NR];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  ctx_switch_ctrl #(.NUM_TASKS(NT), .NUM_REGS(NR), .DATA_W(DW), .BID_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .win_id(win_id), .win_bid(win_bid), .stall(stall),
    .cpu_we(cpu_we), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
    .cpu_raddr(cpu_raddr), .cpu_rdata(cpu_rdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .run_valid(run_valid), .run_id(run_id), .idle(idle)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Dual-ported task memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr_en) tmem[mem_wr_addr] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= tmem[mem_rd_addr];
  end

  function automatic logic [DW-1:0] seed_val(input int t, input int r);
    return 32'hC000_0000 + DW'(t * 4096) + DW'(r * 37) + 32'h5;
  endfunction

  function automatic logic [AW-1:0] addr_of(input int t, input int r);
    return AW'(t * NR + r);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One cycle: check the combinational read, record the write, advance
  task automatic cyc();
    logic [DW-1:0] want;
    #1;
    want = run_valid ? exp_r[run_id][cpu_raddr] : '0;
    chk(cpu_rdata == want, "R2", "cpu read", cpu_rdata, want); // R9 via resumed state
    if (cpu_we && run_valid) exp_r[run_id][cpu_waddr] = cpu_wdata;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20020218));
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < NR; r++) begin
        tmem[t*NR + r] = seed_val(t, r);
        exp_r[t][r]    = seed_val(t, r);
      end
    rst_n = 1'b0; win_id = '0; win_bid = '0; stall = 1'b0;
    cpu_we = 1'b0; cpu_waddr = '0; cpu_wdata = '0; cpu_raddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(idle && !run_valid && !mem_rd_en && !mem_wr_en, "R1", "in reset",
        {idle, run_valid, mem_rd_en, mem_wr_en}, 4'b1000);
    rst_n = 1'b1;
    cycles(4);
    chk(idle && !run_valid && !mem_rd_en && !mem_wr_en, "R1", "after release",
        {idle, run_valid, mem_rd_en, mem_wr_en}, 4'b1000);

    // R3: from idle, task 3 with bid 4
    win_id = 3'd3; win_bid = 4'd4;
    for (int k = 0; k < NR; k++) begin
      cyc();
      chk(mem_rd_en && mem_rd_addr == addr_of(3, k), "R3", "preload address",
          {mem_rd_en, mem_rd_addr}, {1'b1, addr_of(3, k)});
    end
    cyc();
    cyc();
    chk(!run_valid, "R3", "not yet running at N+2", run_valid, 0);
    cyc();
    chk(run_valid && run_id == 3'd3 && !idle, "R3", "running at N+3", run_id, 3);

    // R2: CPU writes then reads of task 3
    for (int r = 0; r < 4; r++) begin
      cpu_we = 1'b1; cpu_waddr = RW'(r); cpu_wdata = $urandom; cpu_raddr = RW'(r);
      cyc();
    end
    cpu_we = 1'b0;
    for (int r = 0; r < NR; r++) begin
      cpu_raddr = RW'(r);
      cyc();
    end

    // R4: lower bid without stall does not preempt (standby fills meanwhile)
    win_id = 3'd5; win_bid = 4'd2;
    cycles(3 * NR);
    chk(run_valid && run_id == 3'd3, "R4", "lower bid keeps runner", run_id, 3);

    // R4: higher bid swaps at once from the ready standby; R7 write-back follows
    win_bid = 4'd7;
    cyc();
    chk(run_valid && run_id == 3'd5, "R4", "higher bid swaps next edge", run_id, 5);
    for (int k = 0; k < NR; k++) begin
      chk(mem_wr_en && mem_wr_addr == addr_of(3, k) && mem_wr_data == exp_r[3][k],
          "R7", "write-back beat", mem_wr_data, exp_r[3][k]);
      cyc();
    end
    chk(!mem_wr_en, "R7", "write-back length", mem_wr_en, 0);

    // R5: stalled runner that is also the winner stays
    stall = 1'b1;
    cycles(20);
    chk(run_valid && run_id == 3'd5, "R5", "stalled winner holds", run_id, 5);

    // R4: stall lets a lower bidder in after a full preload
    win_id = 3'd3; win_bid = 4'd1;
    cycles(NR + 2);
    chk(run_id == 3'd5, "R4", "stall switch not before fill", run_id, 5);
    cyc();
    chk(run_valid && run_id == 3'd3, "R4", "stall switch after fill", run_id, 3);
    stall = 1'b0;
    cycles(NR + 2);

    // R6: zero bid drops to idle on the next edge
    win_bid = 4'd0;
    cyc();
    chk(!run_valid && idle, "R6", "idle after zero bid", {run_valid, idle}, 2'b01);
    cpu_raddr = 3'd2;
    cycles(NR + 2);

    // R9 / R2: random bids, stalls and CPU traffic
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(15) == 0) begin
        win_id  = TW'($urandom_range(NT - 1));
        win_bid = ($urandom_range(7) == 0) ? '0 : BW'($urandom_range(15, 1));
      end
      stall     = ($urandom_range(9) == 0);
      cpu_we    = $urandom_range(1) == 1;
      cpu_waddr = RW'($urandom_range(NR - 1));
      cpu_raddr = RW'($urandom_range(NR - 1));
      cpu_wdata = $urandom;
      cyc();
    end

    // R9: all state back in memory after going idle
    win_bid = '0; stall = 1'b0; cpu_we = 1'b0;
    cycles(4 * NR);
    chk(idle, "R6", "final idle", idle, 1);
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < NR; r++)
        chk(tmem[t*NR + r] == exp_r[t][r], "R9", "saved state", tmem[t*NR + r], exp_r[t][r]);

    done = 1;
    summary();
    $finish;
  end

endmodule